// File: doc/BRIEF.md
# Quad-Data-Rate Four-Word Burst Memory

This block is a synthesizable, cycle-accurate functional model of a static memory with a dedicated read data port and a dedicated write data port. One address bus serves both ports. A read address and a write address are taken on alternate command edges, and each address names a row of four words that moves as a burst at double data rate. The read port and the write port run concurrently, so their bursts overlap and neither port ever waits on the other.

True dual-edge logic is avoided. The model runs on a beat clock at twice the command rate, and a free-running two-bit beat counter (`beat_slot`) marks the beats. A four-beat frame holds one read command beat (slot 0) and one write command beat (slot 2). Each port carries one word per beat. A read returns its burst four beats after the read command, which is 2.0 command-clock cycles, and a valid flag frames that burst. The data is coherent with a write whose final word is still arriving when the read row is fetched.

Top module: `qdr_burst_sram`

## Requirements
- R1: While `rst_n` is low, `rvalid` is 0, `rdata` is 0 and `beat_slot` is 0.
- R2: After reset, `beat_slot` steps 0,1,2,3,0,... once per beat clock. The select and address inputs are only taken on slot-0 beats (read) and slot-2 beats (write); on other beats they have no effect.
- R3: A low `rd_sel_n` on a slot-0 beat sets `rvalid` high for exactly the four beats that follow four beats later, which are the beats showing slot 1, 2, 3 and then 0. A high `rd_sel_n` on a slot-0 beat leaves `rvalid` low for those four beats.
- R4: A read burst presents words 0,1,2,3 of the addressed row in that order, one per beat. Word k is array location {address, k}. `rdata` is 0 whenever `rvalid` is low.
- R5: A low `wr_sel_n` on a slot-2 beat captures `wdata` on the next four beats as words 0,1,2,3 of the addressed row. With `wr_sel_n` high on the slot-2 beat, the row is not changed.
- R6: A read returns the newest data of every write whose command beat came before the read command beat. This includes the write of the previous frame, whose last word arrives on the same beat as the read row is fetched.
- R7: A write issued in the same frame as a read (slot 2, after the read's slot 0) is not visible to that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read select, taken on slot 0 |
| wr_sel_n | input | 1 | Active-low write select, taken on slot 2 |
| addr | input | AW | Shared row address (read on slot 0, write on slot 2) |
| wdata | input | DW | Write data, one word per beat |
| rdata | output | DW | Read data, one word per beat |
| rvalid | output | 1 | High while `rdata` carries a read burst word |
| beat_slot | output | 2 | Position of the current beat within the frame |

## Verification
The bench runs a nine-bit, eight-row configuration. It writes every row, reads every row back, and then sweeps many frames with random selects and clustered addresses, so that reads and writes to the same row often fall one frame apart or in the same frame. A model that fetched the read row without forwarding the write still in flight would return stale words right after a write. A model that let a same-frame write leak into the read would return new data too early. A latency or ordering slip shows up as `rvalid` framing the wrong beats, or as words rotated within the burst. Junk selects and addresses on the non-command beats catch a design that samples them on the wrong edge.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
   localparam int WORDS  = 4;
   localparam int WIDX_W = 2;

   typedef enum logic [1:0] {
      SL_RCMD = 2'd0,
      SL_B1   = 2'd1,
      SL_WCMD = 2'd2,
      SL_B3   = 2'd3
   } slot_e;
endpackage

// File: rtl/qdr_slot_timer.sv
module qdr_slot_timer
   import qdr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   output slot_e slot
);
   logic [WIDX_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   assign slot = slot_e'(cnt);

   // the frame position advances by exactly one every beat
   p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt == $past(cnt) + 2'd1));
endmodule

// File: rtl/qdr_wr_port.sv
module qdr_wr_port
   import qdr_pkg::*;
#(
   parameter int DW = 18,
   parameter int AW = 4
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  slot_e                     slot,
   input  logic                      wr_sel_n,
   input  logic [AW-1:0]             addr,
   input  logic [DW-1:0]             wdata,
   output logic                      busy,
   output logic [AW-1:0]             waddr,
   output logic [WORDS-1:0][DW-1:0]  row,
   output logic                      commit
);
   logic [WORDS-2:0][DW-1:0] cap;
   logic [WIDX_W-1:0]        widx;

   // beat after the write command carries word 0
   assign widx = WIDX_W'(slot) + 2'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         waddr <= '0;
         cap   <= '0;
      end else if (slot == SL_WCMD) begin
         busy  <= ~wr_sel_n;
         waddr <= addr;
      end else if (busy) begin
         cap[widx] <= wdata;
      end
   end

   // last word goes straight from the pins into the committed row
   generate
      for (genvar k = 0; k < WORDS - 1; k++) begin : g_row
         assign row[k] = cap[k];
      end
   endgenerate
   assign row[WORDS-1] = wdata;
   assign commit       = busy && (slot == SL_WCMD);

   p_busy_from_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SL_WCMD) |=> (busy == !$past(wr_sel_n)));
endmodule

// File: rtl/qdr_array.sv
module qdr_array
   import qdr_pkg::*;
#(
   parameter int DW    = 18,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
)(
   input  logic                      clk,
   input  logic                      we,
   input  logic [AW-1:0]             waddr,
   input  logic [WORDS-1:0][DW-1:0]  wrow,
   input  logic [AW-1:0]             raddr,
   output logic [WORDS-1:0][DW-1:0]  rrow
);
   logic [DW-1:0] mem [DEPTH*WORDS];

   generate
      for (genvar k = 0; k < WORDS; k++) begin : g_word
         always_ff @(posedge clk) begin
            if (we) mem[{waddr, WIDX_W'(k)}] <= wrow[k];
         end
         assign rrow[k] = mem[{raddr, WIDX_W'(k)}];
      end
   endgenerate
endmodule

// File: rtl/qdr_rd_port.sv
module qdr_rd_port
   import qdr_pkg::*;
#(
   parameter int DW = 18,
   parameter int AW = 4
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  slot_e                     slot,
   input  logic                      rd_sel_n,
   input  logic [AW-1:0]             addr,
   input  logic                      wr_busy,
   input  logic [AW-1:0]             wr_addr,
   input  logic [WORDS-1:0][DW-1:0]  wr_row,
   input  logic [WORDS-1:0][DW-1:0]  arr_row,
   output logic [AW-1:0]             raddr,
   output logic [DW-1:0]             rdata,
   output logic                      rvalid
);
   logic                      rq_v, snap_v, hit;
   logic [WORDS-1:0][DW-1:0]  merged, snap;
   logic [WORDS-2:0][DW-1:0]  sh;

   assign raddr = raddr_q;
   logic [AW-1:0] raddr_q;

   // the write completing on this beat overrides the stale array row
   assign hit = wr_busy && (wr_addr == raddr_q);
   generate
      for (genvar k = 0; k < WORDS; k++) begin : g_fwd
         assign merged[k] = hit ? wr_row[k] : arr_row[k];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rq_v    <= 1'b0;
         raddr_q <= '0;
         snap_v  <= 1'b0;
         snap    <= '0;
         sh      <= '0;
         rdata   <= '0;
         rvalid  <= 1'b0;
      end else begin
         if (slot == SL_RCMD) begin
            rq_v    <= ~rd_sel_n;
            raddr_q <= addr;
         end
         if (slot == SL_WCMD) begin
            snap_v <= rq_v;
            snap   <= merged;
         end
         if (slot == SL_RCMD) begin
            rvalid <= snap_v;
            rdata  <= snap_v ? snap[0] : '0;
            sh     <= {snap[3], snap[2], snap[1]};
         end else begin
            rdata  <= rvalid ? sh[0] : '0;
            sh     <= {{DW{1'b0}}, sh[2], sh[1]};
         end
      end
   end

   p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SL_RCMD && !rd_sel_n) |=> ##4 rvalid);
   p_nolaunch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SL_RCMD && rd_sel_n) |=> ##4 !rvalid);
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot != SL_RCMD) |=> (rvalid == $past(rvalid)));
   p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> (rdata == '0));
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
   import qdr_pkg::*;
#(
   parameter int DW    = 18,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_sel_n,
   input  logic          wr_sel_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          rvalid,
   output logic [1:0]    beat_slot
);
   if (!(DW == 8 || DW == 9 || DW == 18 || DW == 36)) begin : g_bad_dw
      $error("qdr_burst_sram: DW must be 8, 9, 18 or 36");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("qdr_burst_sram: DEPTH must be a power of two, at least 2");
   end

   slot_e                     slot;
   logic                      wr_busy, commit;
   logic [AW-1:0]             wr_addr, raddr;
   logic [WORDS-1:0][DW-1:0]  wr_row, arr_row;

   qdr_slot_timer u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot)
   );

   qdr_wr_port #(.DW(DW), .AW(AW)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot     (slot),
      .wr_sel_n (wr_sel_n),
      .addr     (addr),
      .wdata    (wdata),
      .busy     (wr_busy),
      .waddr    (wr_addr),
      .row      (wr_row),
      .commit   (commit)
   );

   qdr_array #(.DW(DW), .DEPTH(DEPTH)) u_array (
      .clk   (clk),
      .we    (commit),
      .waddr (wr_addr),
      .wrow  (wr_row),
      .raddr (raddr),
      .rrow  (arr_row)
   );

   qdr_rd_port #(.DW(DW), .AW(AW)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot     (slot),
      .rd_sel_n (rd_sel_n),
      .addr     (addr),
      .wr_busy  (wr_busy),
      .wr_addr  (wr_addr),
      .wr_row   (wr_row),
      .arr_row  (arr_row),
      .raddr    (raddr),
      .rdata    (rdata),
      .rvalid   (rvalid)
   );

   assign beat_slot = 2'(slot);
endmodule

// File: tb/qdr_burst_sram_bench.sv
module qdr_burst_sram_bench;
   localparam int DW    = 9;
   localparam int DEPTH = 8;
   localparam int AW    = 3;
   localparam int NF    = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_sel_n = 1'b1, wr_sel_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rvalid;
   logic [1:0]    beat_slot;

   int n_chk = 0, n_fail = 0, n_frames = 0;

   bit            fr_rd [NF];
   bit            fr_wr [NF];
   logic [AW-1:0] fr_ra [NF];
   logic [AW-1:0] fr_wa [NF];
   logic [DW-1:0] ex    [NF][4];
   bit            ex_fw [NF];
   bit            ex_same [NF];
   logic [DW-1:0] refm  [DEPTH][4];

   always #10 clk = ~clk;

   qdr_burst_sram #(.DW(DW), .DEPTH(DEPTH)) u_qdr_burst_sram (
      .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
      .beat_slot(beat_slot)
   );

   function automatic logic [DW-1:0] dat(int f, int j);
      return DW'((f * 37 + j * 53 + 7) % 512);
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic plan(int f, bit rd, int ra, bit wr, int wa);
      fr_rd[f] = rd; fr_ra[f] = AW'(ra);
      fr_wr[f] = wr; fr_wa[f] = AW'(wa);
      n_frames = f + 1;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int unsigned st = 32'h1234;
      int f;
      for (int i = 0; i < NF; i++) plan(i, 0, 0, 0, 0);
      for (int i = 0; i < 8; i++) plan(i, 0, 0, 1, i);         // fill all rows
      for (int i = 0; i < 8; i++) plan(8 + i, 1, i, 0, 0);     // read all rows
      plan(16, 0, 0, 1, 3);
      plan(17, 1, 3, 1, 3);   // R6: previous frame write forwarded
      plan(18, 1, 3, 0, 0);
      plan(19, 1, 5, 1, 5);   // R7: same-frame write stays hidden
      plan(20, 1, 5, 0, 0);
      plan(21, 0, 0, 0, 0);
      plan(22, 1, 5, 0, 0);
      f = 23;
      for (int i = 0; i < 160; i++) begin
         st = st * 1103515245 + 12345;
         plan(f, st[20], int'(st[18:17]) + 2 * int'(st[22]),
                 st[21] | st[19], int'(st[24:23]) + 2 * int'(st[25]));
         f++;
      end
      for (int i = 0; i < 4; i++) begin plan(f, 0, 0, 0, 0); f++; end

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(rvalid == 1'b0, "R1 rvalid in reset", rvalid, 0);
      chk(rdata == '0, "R1 rdata in reset", rdata, 0);
      chk(beat_slot == 2'd0, "R1 slot in reset", beat_slot, 0);
      @(posedge clk); #1 rst_n = 1'b1;

      for (int fr = 0; fr < n_frames; fr++) begin
         for (int s = 0; s < 4; s++) begin
            int fo, k, wf, j;
            @(negedge clk);
            chk(beat_slot == 2'(s), "R2 beat slot", beat_slot, s);
            fo = (s == 0) ? fr - 2 : fr - 1;
            k  = (s + 3) % 4;
            if (fo >= 0 && fr_rd[fo]) begin
               chk(rvalid == 1'b1, "R3 rvalid in burst", rvalid, 1);
               if (ex_same[fo])
                  chk(rdata == ex[fo][k], "R7 same-frame write hidden", rdata, ex[fo][k]);
               else if (ex_fw[fo])
                  chk(rdata == ex[fo][k], "R6 in-flight write forwarded", rdata, ex[fo][k]);
               else
                  chk(rdata == ex[fo][k], "R4 R5 burst word", rdata, ex[fo][k]);
            end else begin
               chk(rvalid == 1'b0, "R3 rvalid idle", rvalid, 0);
               chk(rdata == '0, "R4 rdata idle", rdata, 0);
            end
            // drive: selects and address only meaningful on command beats
            if (s == 0) begin
               rd_sel_n = !fr_rd[fr];
               addr     = fr_ra[fr];
               wr_sel_n = fr[0];
               if (fr_rd[fr]) begin
                  for (int q = 0; q < 4; q++) ex[fr][q] = refm[fr_ra[fr]][q];
                  ex_fw[fr]   = (fr > 0) && fr_wr[fr-1] && fr_wa[fr-1] == fr_ra[fr];
                  ex_same[fr] = fr_wr[fr] && fr_wa[fr] == fr_ra[fr];
               end
            end else if (s == 2) begin
               wr_sel_n = !fr_wr[fr];
               addr     = fr_wa[fr];
               rd_sel_n = fr[1];
               if (fr_wr[fr])
                  for (int q = 0; q < 4; q++) refm[fr_wa[fr]][q] = dat(fr, q);
            end else begin
               rd_sel_n = fr[0];
               wr_sel_n = fr[1];
               addr     = AW'(fr * 5 + s);
            end
            wf = (s == 3) ? fr : fr - 1;
            j  = (s + 1) % 4;
            if (wf >= 0 && fr_wr[wf]) wdata = dat(wf, j);
            else                      wdata = dat(fr + 100, s);
         end
      end
      finish_run();
   end
endmodule